// File: doc/BRIEF.md
# Fixed-Point Base-2 Antilogarithm Unit

This unit turns a 16-bit fixed-point exponent into an approximation of two raised to that exponent. The four upper input bits form the integer characteristic `k` (0 to 15). The twelve lower bits form the fraction `m`. The fractional power is approximated linearly, 2^m ≈ 1 + m, so the result is (1 + m) · 2^k.

The datapath builds a 16-bit word from a forced leading one, the twelve mantissa bits and three zero bits below them. It reads this word as 1.f with the binary point just under bit 15. Two barrel shifters built from power-of-two stages then work in parallel. The right shifter moves the word down by 15 − k to give the integer part. The left shifter moves it up by k + 1 so that the bits below the binary point sit at the top of a 16-bit fraction output.

The shifters are combinational and feed one output register. A valid flag travels beside the data with the same one-cycle delay. The data registers load only on valid cycles, so the last result stays on the outputs until new valid data arrives. The unit has no state machine; its only state is the output register and its valid bit.

Top module: `mitchell_antilog`

## Requirements
- R1: The integer output equals the word {1, in_value[11:0], 000} shifted right by 15 − in_value[15:12], zero-extended to 16 bits.
- R2: The fraction output equals the low 16 bits of the same word shifted left by in_value[15:12] + 1.
- R3: An input of 16'h0000 gives integer part 1 and fraction part 0.
- R4: A characteristic of 15 gives the full word {1, mantissa, 000} as the integer part and a fraction part of 0.
- R5: A characteristic of 0 gives integer part 1 and fraction part {mantissa, 4'b0000}.
- R6: out_valid equals in_valid as it was one clock earlier.
- R7: While in_valid is low, int_part and frac_part keep their values.
- R8: While rst is high and after it is released, out_valid, int_part and frac_part read 0 until the first valid input.
- R9: Whenever out_valid is high, int_part is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_value as a new exponent |
| in_value | input | 16 | Exponent: [15:12] characteristic, [11:0] fraction |
| out_valid | output | 1 | Result registered from the previous cycle's valid input |
| int_part | output | 16 | Integer part of the approximate power |
| frac_part | output | 16 | Fraction part, aligned to the most significant bit |

## Verification
The hardest case to reach is a fraction shift of exactly sixteen. With a characteristic of 15, every bit leaves the left shifter and only the top shifter stage is active. At the same time the right shifter does no shifting at all. The bench drives both extremes of the characteristic with all-zero and all-ones mantissas. It then sends random exponents while in_valid switches at random, which checks that the data holds during idle cycles.

// File: rtl/mitchell_antilog_pkg.sv
package mitchell_antilog_pkg;
    // default geometry of the exponent word
    localparam int CHAR_W_DEF = 4;
    localparam int MANT_W_DEF = 12;

    typedef enum logic {
        SHIFT_RIGHT = 1'b0,
        SHIFT_LEFT  = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/mitchell_log_shifter.sv
module mitchell_log_shifter
    import mitchell_antilog_pkg::*;
#(
    parameter int         WIDTH = 16,
    parameter int         AMT_W = 4,
    parameter shift_dir_e DIR   = SHIFT_RIGHT
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    output logic [WIDTH-1:0] data_out
);
    logic [WIDTH-1:0] stage [0:AMT_W];

    assign stage[0] = data_in;

    // one mux level per bit of the shift amount
    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int DIST = 1 << s;
        if (DIR == SHIFT_LEFT) begin : g_left
            assign stage[s+1] = amount[s] ? (stage[s] << DIST) : stage[s];
        end else begin : g_right
            assign stage[s+1] = amount[s] ? (stage[s] >> DIST) : stage[s];
        end
    end

    assign data_out = stage[AMT_W];
endmodule

// File: rtl/mitchell_antilog.sv
module mitchell_antilog
    import mitchell_antilog_pkg::*;
#(
    parameter int CHAR_W = CHAR_W_DEF,
    parameter int MANT_W = MANT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [CHAR_W+MANT_W-1:0] in_value,
    output logic                    out_valid,
    output logic [(1<<CHAR_W)-1:0]  int_part,
    output logic [(1<<CHAR_W)-1:0]  frac_part
);
    localparam int WORD_W = 1 << CHAR_W;
    localparam int PAD_W  = WORD_W - 1 - MANT_W;
    localparam int FAMT_W = CHAR_W + 1;

    logic [CHAR_W-1:0] chr;
    logic [MANT_W-1:0] mant;
    logic [WORD_W-1:0] word;
    logic [CHAR_W-1:0] int_amt;
    logic [FAMT_W-1:0] frac_amt;
    logic [WORD_W-1:0] int_next;
    logic [WORD_W-1:0] frac_next;

    assign chr  = in_value[CHAR_W+MANT_W-1:MANT_W];
    assign mant = in_value[MANT_W-1:0];
    assign word = {1'b1, mant, {PAD_W{1'b0}}};

    // right distance (WORD_W-1) - k equals bitwise inverse of k
    assign int_amt  = ~chr;
    assign frac_amt = {1'b0, chr} + FAMT_W'(1);

    mitchell_log_shifter #(
        .WIDTH(WORD_W), .AMT_W(CHAR_W), .DIR(SHIFT_RIGHT)
    ) u_int_shift (
        .data_in(word), .amount(int_amt), .data_out(int_next)
    );

    mitchell_log_shifter #(
        .WIDTH(WORD_W), .AMT_W(FAMT_W), .DIR(SHIFT_LEFT)
    ) u_frac_shift (
        .data_in(word), .amount(frac_amt), .data_out(frac_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            int_part  <= '0;
            frac_part <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                int_part  <= int_next;
                frac_part <= frac_next;
            end
        end
    end

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(int_part) && $stable(frac_part)));

    // R9
    int_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int_part != '0));

    // R4
    top_char_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (chr == '1)) |=> (frac_part == '0 && int_part[WORD_W-1]));
endmodule

// File: tb/mitchell_antilog_test.sv
module mitchell_antilog_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_value = '0;
    logic        out_valid;
    logic [15:0] int_part;
    logic [15:0] frac_part;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    logic        m_valid = 1'b0;
    logic [15:0] m_int = '0;
    logic [15:0] m_frac = '0;

    always #10 clk = ~clk;

    mitchell_antilog uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
        .out_valid(out_valid), .int_part(int_part), .frac_part(frac_part)
    );

    function automatic logic [15:0] ref_int(input logic [15:0] x);
        longint w = 64'd32768 + longint'(x[11:0]) * 8;
        return 16'(w >> (15 - int'(x[15:12])));
    endfunction

    function automatic logic [15:0] ref_frac(input logic [15:0] x);
        longint w = 64'd32768 + longint'(x[11:0]) * 8;
        longint v = w << (int'(x[15:12]) + 1);
        return v[15:0];
    endfunction

    // behavioural reference, one register deep
    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0; m_int <= '0; m_frac <= '0;
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                m_int  <= ref_int(in_value);
                m_frac <= ref_frac(in_value);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        chk("R6 out_valid", {15'b0, out_valid}, {15'b0, m_valid});
        chk("R1/R7 int_part", int_part, m_int);
        chk("R2/R7 frac_part", frac_part, m_frac);
        if (out_valid) chk("R9 int nonzero", {15'b0, int_part != 0}, 16'd1);
    endtask

    task automatic cyc(input logic [15:0] x, input logic v);
        in_value = x;
        in_valid = v;
        @(negedge clk);
        compare_model();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {15'b0, out_valid}, 16'd0);
        chk("R8 reset int", int_part, 16'd0);
        chk("R8 reset frac", frac_part, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 after release int", int_part, 16'd0);

        cyc(16'h0000, 1'b1);
        chk("R3 zero int", int_part, 16'd1);
        chk("R3 zero frac", frac_part, 16'd0);

        cyc(16'hFABC, 1'b1);
        chk("R4 k15 int", int_part, {1'b1, 12'hABC, 3'b000});
        chk("R4 k15 frac", frac_part, 16'd0);

        cyc(16'hFFFF, 1'b1);
        chk("R4 k15 ones int", int_part, 16'hFFF8);
        chk("R4 k15 ones frac", frac_part, 16'd0);

        cyc(16'h0FFF, 1'b1);
        chk("R5 k0 int", int_part, 16'd1);
        chk("R5 k0 frac", frac_part, 16'hFFF0);

        cyc(16'h8800, 1'b1);
        chk("R1 k8 int", int_part, 16'h0180);
        chk("R2 k8 frac", frac_part, 16'h0000);

        cyc(16'h3400, 1'b1);
        chk("R1 k3 int", int_part, 16'h000A);
        chk("R2 k3 frac", frac_part, 16'h0000);

        cyc(16'h1234, 0);
        chk("R7 idle int", int_part, 16'h000A);
        chk("R6 idle valid", {15'b0, out_valid}, 16'd0);

        for (int i = 0; i < 3000; i++) begin
            cyc(16'($urandom), 1'($urandom % 3 != 0));
        end
        cyc(16'h0000, 1'b0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule